// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Unit with Early-NMOS Flag Behaviour

This block is the add-with-carry and subtract-with-borrow part of an 8-bit processor ALU. It works either on plain binary bytes or on packed binary-coded decimal bytes, where each byte holds two decimal digits. In decimal mode it reproduces, bit for bit, the result byte and the negative, overflow, zero and carry flags of an early NMOS 8-bit processor. That includes operands whose nibbles are not valid decimal digits. Only the carry flag carries meaningful decimal information. The other three flags come from intermediate or binary values.

The datapath is made of two 4-bit binary nibble adders with a decimal correction between the nibbles. For addition, the carry from the low nibble into the high nibble is corrected. For subtraction, each nibble is corrected on its own borrow, and no extra carry is passed between them. The caller presents two operand bytes, a carry-in, a decimal enable and an add/subtract select together with a one-cycle valid strobe. One clock later the registered result and flags appear, with an output-valid pulse. The outputs hold until the next strobe.

Top module: `bcd_addsub_unit`

## Requirements
- R1: With decEn=0 and subSel=0, result = (opA + opB + carryIn) mod 256, flagC = bit 8 of that sum, flagN = result bit 7, flagZ = (result == 0), and flagV is set when both operands have equal bit 7 and the result bit 7 differs from it.
- R2: With decEn=0 and subSel=1, the unit computes opA + ~opB + carryIn. Carry-in 1 means no borrow. flagC = 1 means no borrow out. N, Z and V follow R1 applied to opA and ~opB.
- R3: With decEn=1 and subSel=0, the steps are as follows:
  - Form lo = opA[3:0] + opB[3:0] + carryIn. When lo ≥ 10, lo becomes ((lo + 6) mod 16) + 16.
  - Form s = opA[7:4]·16 + opB[7:4]·16 + lo.
  - When s ≥ 0xA0, add 0x60 to s.
  - result = s mod 256 and flagC = (s ≥ 0x100). For valid BCD operands both result digits are valid BCD.
- R4: In decimal addition, flagN is bit 7 of s before the 0x60 correction. flagV is bit 7 of (opA ^ s) & (opB ^ s), also taken before that correction.
- R5: In decimal addition, flagZ is set exactly when (opA + opB + carryIn) mod 256 is zero, regardless of the corrected result.
- R6: With decEn=1 and subSel=1, the steps are as follows:
  - Form lo = opA[3:0] − opB[3:0] + carryIn − 1. When lo < 0, lo becomes ((lo − 6) mod 16) − 16.
  - Form d = opA[7:4]·16 − opB[7:4]·16 + lo. When d < 0, subtract 0x60 from d.
  - result = d mod 256. An invalid low nibble such as 0x0A minus 0x00 with carryIn=1 passes through unchanged.
- R7: In decimal subtraction, flagN, flagV, flagZ and flagC equal the flags of the binary subtraction in R2 on the same inputs.
- R8: Inputs are captured on a clock edge where inValid=1. Result and flags change at that edge and outValid is high for exactly the following cycle. With inValid=0, outValid is low and result and flags hold.
- R9: A synchronous reset clears result, all four flags and outValid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands valid, captured at this edge |
| opA | input | 8 | First operand (minuend for subtract) |
| opB | input | 8 | Second operand (subtrahend for subtract) |
| carryIn | input | 1 | Carry in; for subtract 1 means no borrow |
| decEn | input | 1 | 1 selects packed-BCD arithmetic |
| subSel | input | 1 | 0 add, 1 subtract |
| result | output | 8 | Result byte |
| flagN | output | 1 | Negative flag |
| flagV | output | 1 | Overflow flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry / not-borrow flag |
| outValid | output | 1 | High for the cycle after a capture |

## Verification
Every result and flag is due exactly one clock after the edge that captures the operands. The bench drives a new vector on each falling edge and checks the outputs on the next falling edge. At that point the registers have taken the previous vector, and the check runs just before the next vector is driven, so back-to-back vectors are checked without gaps. After an idle edge the outputs must be unchanged and outValid low. After a reset edge everything must read zero at the following falling edge. Expected values come from an integer model of the requirements plus literal values for the known decimal corner cases.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load new result and flags
    logic clear;    // reset result and flags
  } ctrlStrobe_t;
endpackage

// File: rtl/bcd_addsub_ctrl.sv
module bcd_addsub_ctrl
  import bcd_addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  assign strobe.capture = inValid & ~rst;
  assign strobe.clear   = rst;

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R9
  reset_valid_chk: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/bcd_addsub_datapath.sv
module bcd_addsub_datapath
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              decEn,
  input  logic              subSel,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC
);

  localparam int unsigned NIB_W  = DATA_W / 2;
  localparam int unsigned MID_W  = DATA_W + 1;   // also signed difference width
  localparam int unsigned FIN_W  = DATA_W + 2;
  localparam int unsigned MSB    = DATA_W - 1;
  localparam logic [NIB_W:0]   DIGIT_LIM = (NIB_W+1)'(10);
  localparam logic [NIB_W-1:0] NIB_FIX   = NIB_W'(6);
  localparam logic [MID_W-1:0] HI_LIM    = MID_W'(10 << NIB_W);
  localparam logic [FIN_W-1:0] HI_FIX    = FIN_W'(6 << NIB_W);
  localparam logic [DATA_W-1:0] HI_FIX_B = DATA_W'(6 << NIB_W);

  logic [NIB_W-1:0] aLo, aHi, bLo, bHi;
  assign aLo = opA[NIB_W-1:0];
  assign aHi = opA[DATA_W-1:NIB_W];
  assign bLo = opB[NIB_W-1:0];
  assign bHi = opB[DATA_W-1:NIB_W];

  // Binary path, shared by both operations
  logic [DATA_W-1:0] opBx;
  logic [DATA_W:0]   binSum;
  logic              binN, binV, binZ, binC;
  always_comb begin
    opBx   = subSel ? ~opB : opB;
    binSum = {1'b0, opA} + {1'b0, opBx} + {{DATA_W{1'b0}}, carryIn};
    binN   = binSum[MSB];
    binZ   = (binSum[DATA_W-1:0] == '0);
    binC   = binSum[DATA_W];
    binV   = (opA[MSB] == opBx[MSB]) && (binSum[MSB] != opA[MSB]);
  end

  // Decimal addition: low nibble corrected, carry fed into high nibble
  logic [NIB_W:0]   addLoRaw, addLoAdj;
  logic [NIB_W-1:0] addLoNib;
  logic [MID_W-1:0] addMid;
  logic [FIN_W-1:0] addFin;
  logic             addN, addV, addC;
  always_comb begin
    addLoRaw = {1'b0, aLo} + {1'b0, bLo} + {{NIB_W{1'b0}}, carryIn};
    addLoNib = addLoRaw[NIB_W-1:0] + NIB_FIX;
    addLoAdj = (addLoRaw >= DIGIT_LIM) ? {1'b1, addLoNib} : addLoRaw;
    addMid   = MID_W'({aHi, {NIB_W{1'b0}}}) + MID_W'({bHi, {NIB_W{1'b0}}})
             + MID_W'(addLoAdj);
    addN     = addMid[MSB];
    addV     = (opA[MSB] ^ addMid[MSB]) & (opB[MSB] ^ addMid[MSB]);
    addFin   = (addMid >= HI_LIM) ? ({1'b0, addMid} + HI_FIX) : {1'b0, addMid};
    addC     = |addFin[FIN_W-1:DATA_W];
  end

  // Decimal subtraction: each nibble corrected on its own borrow (signed)
  logic [MID_W-1:0]  subLoRaw, subLo, subMid;
  logic [NIB_W-1:0]  subLoNib;
  logic [DATA_W-1:0] subFin;
  always_comb begin
    subLoRaw = MID_W'(aLo) - MID_W'(bLo) + MID_W'(carryIn) - MID_W'(1);
    subLoNib = subLoRaw[NIB_W-1:0] - NIB_FIX;
    subLo    = subLoRaw[MID_W-1] ? {{(MID_W-NIB_W){1'b1}}, subLoNib} : subLoRaw;
    subMid   = MID_W'({aHi, {NIB_W{1'b0}}}) - MID_W'({bHi, {NIB_W{1'b0}}}) + subLo;
    subFin   = subMid[MID_W-1] ? (subMid[DATA_W-1:0] - HI_FIX_B) : subMid[DATA_W-1:0];
  end

  // Output selection
  logic [DATA_W-1:0] nextRes;
  logic              nextN, nextV, nextZ, nextC;
  always_comb begin
    nextRes = binSum[DATA_W-1:0];
    nextN   = binN;
    nextV   = binV;
    nextZ   = binZ;
    nextC   = binC;
    if (decEn && !subSel) begin
      nextRes = addFin[DATA_W-1:0];
      nextN   = addN;
      nextV   = addV;
      nextC   = addC;
    end else if (decEn) begin
      nextRes = subFin;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      result <= '0;
      flagN  <= 1'b0;
      flagV  <= 1'b0;
      flagZ  <= 1'b0;
      flagC  <= 1'b0;
    end else if (strobe.capture) begin
      result <= nextRes;
      flagN  <= nextN;
      flagV  <= nextV;
      flagZ  <= nextZ;
      flagC  <= nextC;
    end
  end

  // R1
  bin_add_sum_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && !decEn && !subSel) |=>
      ({flagC, result} == ({1'b0, $past(opA)} + {1'b0, $past(opB)} + (DATA_W+1)'($past(carryIn)))));

  // R3
  dec_add_digits_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && decEn && !subSel && (aLo <= 4'd9) && (aHi <= 4'd9)
      && (bLo <= 4'd9) && (bHi <= 4'd9)) |=>
      ((result[DATA_W-1:NIB_W] <= 4'd9) && (result[NIB_W-1:0] <= 4'd9)));

  // R5
  dec_add_zero_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && decEn && !subSel) |=>
      (flagZ == (DATA_W'($past(opA) + $past(opB) + DATA_W'($past(carryIn))) == '0)));

  // R7
  dec_sub_borrow_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && decEn && subSel) |=>
      (flagC == (($past(opA) > $past(opB)) || (($past(opA) == $past(opB)) && $past(carryIn)))));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (!$past(strobe.capture) && !$past(strobe.clear)) |->
      ($stable(result) && $stable({flagN, flagV, flagZ, flagC})));

endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import bcd_addsub_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              decEn,
  input  logic              subSel,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagV,
  output logic              flagZ,
  output logic              flagC,
  output logic              outValid
);

  ctrlStrobe_t strobe;

  bcd_addsub_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  bcd_addsub_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk     (clk),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .decEn   (decEn),
    .subSel  (subSel),
    .result  (result),
    .flagN   (flagN),
    .flagV   (flagV),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ((result == '0) && !flagN && !flagV && !flagZ && !flagC));

endmodule

// File: tb/bcd_addsub_unit_bench.sv
`timescale 1ns/1ps
module bcd_addsub_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inV = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0, dec = 1'b0, sub = 1'b0;
  logic [7:0] res;
  logic       fN, fV, fZ, fC, oV;

  int checks = 0;
  int errors = 0;

  logic       pend = 1'b0;
  logic [7:0] pA, pB;
  logic       pC, pD, pS;

  always #4 clk = ~clk;

  bcd_addsub_unit u_bcd_addsub_unit (
    .clk(clk), .rst(rst), .inValid(inV), .opA(a), .opB(b), .carryIn(cin),
    .decEn(dec), .subSel(sub), .result(res), .flagN(fN), .flagV(fV),
    .flagZ(fZ), .flagC(fC), .outValid(oV)
  );

  // Integer model: returns {result[7:0], N, V, Z, C}
  function automatic logic [11:0] refModel(input int ia, input int ib, input int ic,
                                           input int id, input int isub);
    int bb, bs, bRes, lo, s, d;
    logic n, v, z, c;
    logic [7:0] r;
    bb   = isub ? (255 - ib) : ib;
    bs   = ia + bb + ic;
    bRes = bs & 255;
    r = bRes[7:0];
    n = bRes[7];
    z = (bRes == 0);
    c = (bs > 255);
    v = (((~(ia ^ bb)) & (ia ^ bRes) & 128) != 0);
    if (id != 0 && isub == 0) begin
      lo = (ia & 15) + (ib & 15) + ic;
      if (lo >= 10) lo = ((lo + 6) & 15) + 16;
      s = (ia & 240) + (ib & 240) + lo;
      n = s[7];
      v = (((ia ^ s) & (ib ^ s) & 128) != 0);
      if (s >= 160) s = s + 96;
      r = s[7:0];
      c = (s >= 256);
    end else if (id != 0) begin
      lo = (ia & 15) - (ib & 15) + ic - 1;
      if (lo < 0) lo = ((lo - 6) & 15) - 16;
      d = (ia & 240) - (ib & 240) + lo;
      if (d < 0) d = d - 96;
      r = d[7:0];
    end
    return {r, n, v, z, c};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h cin=%0d dec=%0d sub=%0d actual=%0h expected=%0h",
               tag, pA, pB, pC, pD, pS, act, exp);
    end
  endtask

  task automatic checkPending();
    logic [11:0] e;
    e = refModel(int'(pA), int'(pB), int'(pC), int'(pD), int'(pS));
    chk("R8 outValid", int'(oV), 1);
    if (!pD && !pS) chk("R1 binary add", int'({res, fN, fV, fZ, fC}), int'(e));
    else if (!pD)   chk("R2 binary sub", int'({res, fN, fV, fZ, fC}), int'(e));
    else if (!pS) begin
      chk("R3 decimal add result/C", int'({res, fC}), int'({e[11:4], e[0]}));
      chk("R4 decimal add N/V", int'({fN, fV}), int'(e[3:2]));
      chk("R5 decimal add Z", int'(fZ), int'(e[1]));
    end else begin
      chk("R6 decimal sub result", int'(res), int'(e[11:4]));
      chk("R7 decimal sub flags", int'({fN, fV, fZ, fC}), int'(e[3:0]));
    end
  endtask

  task automatic send(input logic [7:0] va, input logic [7:0] vb, input logic vc,
                      input logic vd, input logic vs);
    @(negedge clk);
    if (pend) checkPending();
    a = va; b = vb; cin = vc; dec = vd; sub = vs; inV = 1'b1;
    pA = va; pB = vb; pC = vc; pD = vd; pS = vs; pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) checkPending();
    inV = 1'b0;
    pend = 1'b0;
  endtask

  // Decimal corner case with literal expectations; -1 means not checked
  task automatic hard(input logic [7:0] va, input logic [7:0] vb, input logic vc,
                      input logic vs, input int eRes, input int eN, input int eV,
                      input int eZ, input int eC);
    send(va, vb, vc, 1'b1, vs);
    flush();
    if (eRes >= 0) chk(vs ? "R6 corner result" : "R3 corner result", int'(res), eRes);
    if (eC   >= 0) chk(vs ? "R7 corner C" : "R3 corner C", int'(fC), eC);
    if (eN   >= 0) chk(vs ? "R7 corner N" : "R4 corner N", int'(fN), eN);
    if (eV   >= 0) chk(vs ? "R7 corner V" : "R4 corner V", int'(fV), eV);
    if (eZ   >= 0) chk(vs ? "R7 corner Z" : "R5 corner Z", int'(fZ), eZ);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lastRes;
    logic [3:0] lastFlags;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset outputs", int'({res, fN, fV, fZ, fC, oV}), 0);
    rst = 1'b0;

    // Decimal addition corners
    hard(8'h00, 8'h00, 1'b0, 1'b0, 'h00, 0, 0, 1, 0);
    hard(8'h79, 8'h00, 1'b1, 1'b0, 'h80, 1, 1, 0, 0);
    hard(8'h24, 8'h56, 1'b0, 1'b0, 'h80, 1, 1, 0, 0);
    hard(8'h93, 8'h82, 1'b0, 1'b0, 'h75, 0, 1, 0, 1);
    hard(8'h89, 8'h76, 1'b1, 1'b0, -1, -1, -1, 1, 1);
    hard(8'h80, 8'hF0, 1'b0, 1'b0, 'hD0, 0, 1, -1, 1);
    hard(8'h80, 8'hFA, 1'b0, 1'b0, 'hE0, 1, 0, -1, 1);
    hard(8'h2F, 8'h4F, 1'b0, 1'b0, 'h74, 0, 0, 0, 0);
    hard(8'h6F, 8'h00, 1'b1, 1'b0, 'h76, -1, -1, -1, -1);
    // Decimal subtraction corners, including invalid digits
    hard(8'h00, 8'h00, 1'b0, 1'b1, 'h99, 1, 0, 0, 0);
    hard(8'h00, 8'h00, 1'b1, 1'b1, 'h00, 0, 0, 1, 1);
    hard(8'h00, 8'h01, 1'b1, 1'b1, 'h99, 1, -1, -1, 0);
    hard(8'h0A, 8'h00, 1'b1, 1'b1, 'h0A, 0, 0, 0, 1);
    hard(8'h0B, 8'h00, 1'b0, 1'b1, 'h0A, 0, 0, 0, 1);
    hard(8'h9A, 8'h00, 1'b1, 1'b1, 'h9A, 1, 0, 0, 1);
    hard(8'h9B, 8'h00, 1'b0, 1'b1, 'h9A, 1, -1, -1, 1);

    // Idle edge: outputs hold, outValid low (R8)
    lastRes = res;
    lastFlags = {fN, fV, fZ, fC};
    @(negedge clk);
    chk("R8 idle outValid", int'(oV), 0);
    chk("R8 idle hold", int'({res, fN, fV, fZ, fC}), int'({lastRes, lastFlags}));

    // Reset in mid-run clears a nonzero result (R9)
    send(8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
    flush();
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid-run reset", int'({res, fN, fV, fZ, fC, oV}), 0);
    rst = 1'b0;

    // Sweep: all A, B in steps of 5, both carries, all four mode/op pairs
    for (int m = 0; m < 4; m++) begin
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib += 5) begin
          for (int ic = 0; ic < 2; ic++) begin
            send(ia[7:0], ib[7:0], ic[0], m[1], m[0]);
          end
        end
      end
    end
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule